// File: doc/BRIEF.md
# Boot Reset Sequencer

This block decides when a small 8-bit CPU core may leave reset, and it supplies the core's first program address. The external active-low reset pin is synchronised. A low level on it counts as a reset only once it has lasted a minimum real time, which is derived from a clock-frequency parameter. While the reset is accepted, and for a fixed settling time after the pin returns high, the core is held and a clear strobe forces the control registers to zero.

The settling time comes from two 8-bit down-counters joined in a chain. A divide-by-16 prescaler of the input clock drives the first counter, and each underflow of the first counter steps the second. The counters are preloaded with 0xFF and 0x07, so at default parameters the wait lasts 32768 input clocks.

Once the chain runs out, the block drives five read cycles on the bus, each lasting two input clocks (one system-clock period). The first three are dummy reads of page-zero stack addresses S, S-1 and S-2. The last two read the low vector byte from 0xFFFE and then the high vector byte from 0xFFFF. It then loads the program counter and marks the first opcode fetch from that address with SYNC.

Top module: `boot_reset_seq`

## Requirements
- R1: A low level on `rst_pin_n` shorter than the minimum (250 clocks at defaults) is ignored. It neither stretches the settling wait nor disturbs a running core (`core_rst_n` stays 1).
- R2: A low level lasting the minimum or longer is accepted. While it lasts, `core_rst_n`=0, `bus_rd`=0 and `ctl_clear`=1.
- R3: After an accepted low is released, the chained counters (prescale 16, preloads 0xFF and 0x07) wait exactly 32768 clocks. The first stack read appears 32771 rising edges after the pin rises, which adds two synchroniser stages and one decision cycle.
- R4: The three dummy reads put {0x00,S}, {0x00,S-1} and {0x00,S-2} on `bus_addr` with `bus_rd`=1, two clocks each. The subtraction wraps modulo 256.
- R5: The vector reads address 0xFFFE and then 0xFFFF, two clocks each, with `bus_rd`=1. Each byte is taken from `bus_rdata` in the second clock of its read.
- R6: `pc_load` is a single-clock pulse in the first clock of the opcode fetch. In that clock `pc_value` = {byte from 0xFFFF, byte from 0xFFFE}, and `core_rst_n` rises in the same clock.
- R7: `sync` is 1 only during the two-clock opcode fetch at the loaded vector address. After that fetch the block releases the bus (`bus_rd`=0, `sync`=0).
- R8: `ctl_clear` is 1 during the hold and during the settling wait, and 0 from the first stack read on.
- R9: An accepted low during the settling wait returns the block to hold. A full 32768-clock wait then starts again from the next release.
- R10: While `por_n` is low, the block is in hold: `core_rst_n`=0, `ctl_clear`=1, `bus_rd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| por_n | input | 1 | Synchronous active-low power-on reset |
| rst_pin_n | input | 1 | External reset pin, asynchronous, active low |
| sp_in | input | 8 | Current stack pointer S |
| bus_rdata | input | 8 | Read data from memory |
| bus_addr | output | 16 | Address during the boot bus sequence |
| bus_rd | output | 1 | Read strobe for the boot bus sequence |
| sync | output | 1 | First-opcode-fetch marker |
| core_rst_n | output | 1 | Active-low reset held on the CPU core |
| ctl_clear | output | 1 | Forces control registers to 0x00 |
| pc_load | output | 1 | Program-counter load pulse |
| pc_value | output | 16 | Reset vector to load into the program counter |

## Verification
Full boot runs are made with three stack values: a mid-range one, 0x01 and 0x00. The last two push S-1 and S-2 across the wrap, so they separate modulo-256 stack addressing from a carry into the high byte. Different vector byte pairs catch swapped high and low bytes.

A 100-clock low pulse is applied in two places: during the wait, where the exact 32771-edge timing must survive, and while the core runs. A 400-clock low is applied in the middle of the wait. This separates a true restart with a full fresh wait from a counter that merely pauses or carries on.

// File: rtl/rstseq_pkg.sv
// Package: shared state encoding for the boot reset sequencer.
package rstseq_pkg;
    typedef enum logic [3:0] {
        ST_HOLD,
        ST_WAIT,
        ST_STK0,
        ST_STK1,
        ST_STK2,
        ST_VLO,
        ST_VHI,
        ST_FETCH,
        ST_RUN
    } seq_state_t;
endpackage

// File: rtl/pin_filter.sv
// Module: pin_filter
// Synchronises the asynchronous active-low reset pin with two flops. It
// accepts a low level only after MIN_CYC consecutive low samples.
// Assumes CLK_KHZ * MIN_LOW_NS fits in 32 bits.
module pin_filter #(
    parameter int CLK_KHZ    = 125000,
    parameter int MIN_LOW_NS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_lvl,
    output logic accept
);
    localparam int MIN_CYC = (CLK_KHZ * MIN_LOW_NS + 999999) / 1000000;
    localparam int CW      = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_CYC);

    logic          s1_q, s2_q;
    logic [CW-1:0] low_cnt;

    // Two-flop synchroniser; resets to "low" so power-up counts as held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= pin_n;
            s2_q <= s1_q;
        end
    end

    // Count consecutive low samples, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)             low_cnt <= '0;
        else if (s2_q)          low_cnt <= '0;
        else if (low_cnt != CNT_MAX) low_cnt <= low_cnt + 1'b1;
    end

    assign pin_lvl = s2_q;
    assign accept  = (low_cnt == CNT_MAX) && !s2_q;

    AST_ACCEPT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !$past(s2_q)); // R2
endmodule

// File: rtl/cascade_timer.sv
// Module: cascade_timer
// A prescaler divides the clock by PRESCALE and steps timer A. Each
// underflow of A steps timer B. The expire pulse marks B's underflow.
// Assumes load and run are never both high.
module cascade_timer #(
    parameter int          PRESCALE = 16,
    parameter int          W        = 8,
    parameter logic [7:0]  A_INIT   = 8'hFF,
    parameter logic [7:0]  B_INIT   = 8'h07
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
    localparam logic [W-1:0]  A_LD     = W'(A_INIT);
    localparam logic [W-1:0]  B_LD     = W'(B_INIT);

    logic [PW-1:0] pre_q;
    logic [W-1:0]  a_q, b_q;
    logic          tick, a_uf;

    assign tick   = run && (pre_q == PRE_LAST);
    assign a_uf   = tick && (a_q == '0);
    assign expire = a_uf && (b_q == '0);

    // Prescaler and the two chained down-counters with reload on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            pre_q <= '0;
            a_q   <= A_LD;
            b_q   <= B_LD;
        end else if (run) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) a_q <= (a_q == '0) ? A_LD : a_q - 1'b1;
            if (a_uf) b_q <= (b_q == '0) ? B_LD : b_q - 1'b1;
        end
    end

    AST_A_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && a_q != '0) |=> (a_q == $past(a_q) - 1'b1)); // R3
    AST_B_WAITS_FOR_A: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !a_uf) |=> $stable(b_q)); // R3
endmodule

// File: rtl/boot_reset_seq.sv
// Module: boot_reset_seq (top)
// Holds the CPU core in reset while the pin is low and during the
// chained-timer wait. It then runs three stack dummy reads and two
// vector reads, loads the PC, and flags the first opcode fetch.
// Assumes memory returns bus_rdata combinationally within a clock.
module boot_reset_seq
    import rstseq_pkg::*;
#(
    parameter int         CLK_KHZ    = 125000,
    parameter int         MIN_LOW_NS = 2000,
    parameter int         PRESCALE   = 16,
    parameter logic [7:0] T3_INIT    = 8'hFF,
    parameter logic [7:0] T4_INIT    = 8'h07
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_pin_n,
    input  logic [7:0]  sp_in,
    input  logic [7:0]  bus_rdata,
    output logic [15:0] bus_addr,
    output logic        bus_rd,
    output logic        sync,
    output logic        core_rst_n,
    output logic        ctl_clear,
    output logic        pc_load,
    output logic [15:0] pc_value
);
    localparam logic [15:0] VEC_LO_ADDR = 16'hFFFE;
    localparam logic [15:0] VEC_HI_ADDR = 16'hFFFF;

    seq_state_t state, nxt;
    logic       ph;
    logic [7:0] vec_lo, vec_hi;
    logic       pin_lvl, accept, expire;

    pin_filter #(.CLK_KHZ(CLK_KHZ), .MIN_LOW_NS(MIN_LOW_NS)) u_pin (
        .clk(clk), .rst_n(por_n), .pin_n(rst_pin_n),
        .pin_lvl(pin_lvl), .accept(accept)
    );

    cascade_timer #(.PRESCALE(PRESCALE), .W(8), .A_INIT(T3_INIT), .B_INIT(T4_INIT)) u_tmr (
        .clk(clk), .rst_n(por_n), .load(state == ST_HOLD),
        .run(state == ST_WAIT), .expire(expire)
    );

    // Next-state choice; an accepted reset overrides everything.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD:  if (pin_lvl) nxt = ST_WAIT;
            ST_WAIT:  if (expire)  nxt = ST_STK0;
            ST_STK0:  if (ph)      nxt = ST_STK1;
            ST_STK1:  if (ph)      nxt = ST_STK2;
            ST_STK2:  if (ph)      nxt = ST_VLO;
            ST_VLO:   if (ph)      nxt = ST_VHI;
            ST_VHI:   if (ph)      nxt = ST_FETCH;
            ST_FETCH: if (ph)      nxt = ST_RUN;
            default:               nxt = state;
        endcase
        if (accept) nxt = ST_HOLD;
    end

    // State, half-period phase and vector byte capture.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state  <= ST_HOLD;
            ph     <= 1'b0;
            vec_lo <= 8'h00;
            vec_hi <= 8'h00;
        end else begin
            state <= nxt;
            ph    <= (nxt != state) ? 1'b0 : ~ph;
            if (state == ST_VLO && ph) vec_lo <= bus_rdata;
            if (state == ST_VHI && ph) vec_hi <= bus_rdata;
        end
    end

    // Bus and control outputs decoded from the current state.
    always_comb begin
        bus_addr   = 16'h0000;
        bus_rd     = 1'b0;
        sync       = 1'b0;
        core_rst_n = 1'b0;
        ctl_clear  = 1'b0;
        unique case (state)
            ST_HOLD, ST_WAIT: ctl_clear = 1'b1;
            ST_STK0: begin bus_addr = {8'h00, sp_in};         bus_rd = 1'b1; end
            ST_STK1: begin bus_addr = {8'h00, sp_in - 8'd1};  bus_rd = 1'b1; end
            ST_STK2: begin bus_addr = {8'h00, sp_in - 8'd2};  bus_rd = 1'b1; end
            ST_VLO:  begin bus_addr = VEC_LO_ADDR;            bus_rd = 1'b1; end
            ST_VHI:  begin bus_addr = VEC_HI_ADDR;            bus_rd = 1'b1; end
            ST_FETCH: begin
                bus_addr   = {vec_hi, vec_lo};
                bus_rd     = 1'b1;
                sync       = 1'b1;
                core_rst_n = 1'b1;
            end
            default: core_rst_n = 1'b1;
        endcase
    end

    assign pc_load  = (state == ST_FETCH) && !ph;
    assign pc_value = {vec_hi, vec_lo};

    AST_PCLOAD_PULSE: assert property (@(posedge clk) disable iff (!por_n)
        pc_load |=> !pc_load); // R6
    AST_SYNC_RELEASED: assert property (@(posedge clk) disable iff (!por_n)
        sync |-> core_rst_n); // R7
    AST_CLEAR_NO_BUS: assert property (@(posedge clk) disable iff (!por_n)
        ctl_clear |-> !bus_rd); // R8
    AST_VEC_ORDER: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rd && bus_addr == VEC_HI_ADDR && $past(bus_addr) != VEC_HI_ADDR)
        |-> $past(bus_addr) == VEC_LO_ADDR); // R5
endmodule

// File: tb/sim_boot_reset_seq.sv
// Bench: behavioural per-cycle expectation of the boot sequence, compared
// at every falling edge.
module sim_boot_reset_seq;
    logic        clk = 1'b0;
    logic        por_n, rst_pin_n;
    logic [7:0]  sp, vlo, vhi, bus_rdata;
    logic [15:0] bus_addr, pc_value;
    logic        bus_rd, sync, core_rst_n, ctl_clear, pc_load;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    localparam int WAIT_CLKS = 16 * 256 * 8;   // prescale x timer A x timer B
    localparam int N0        = WAIT_CLKS + 3;   // + 2 sync flops + 1 decision

    always #4 clk = ~clk;   // 125 MHz

    assign bus_rdata = (bus_addr == 16'hFFFE) ? vlo :
                       (bus_addr == 16'hFFFF) ? vhi : (bus_addr[7:0] ^ 8'h5A);

    boot_reset_seq u0 (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .sp_in(sp),
        .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .sync(sync), .core_rst_n(core_rst_n), .ctl_clear(ctl_clear),
        .pc_load(pc_load), .pc_value(pc_value)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic held(input string tag);
        chk({core_rst_n, bus_rd, sync, ctl_clear} == 4'b0001, tag,
            {28'd0, core_rst_n, bus_rd, sync, ctl_clear}, 32'h1);
    endtask

    // Release the pin and follow the whole boot cycle by cycle.
    task automatic boot(input logic [7:0] s, input logic [7:0] lo, input logic [7:0] hi,
                        input int g_at, input string wtag);
        logic [15:0] seq [5];
        seq[0] = {8'h00, s};
        seq[1] = {8'h00, s - 8'd1};
        seq[2] = {8'h00, s - 8'd2};
        seq[3] = 16'hFFFE;
        seq[4] = 16'hFFFF;
        sp = s; vlo = lo; vhi = hi;
        rst_pin_n = 1'b1;
        for (int n = 1; n <= N0 + 16; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n < N0) begin
                held(wtag);                                  // R3 / R1 / R9
            end else if (n < N0 + 10) begin
                int idx = (n - N0) / 2;
                chk({core_rst_n, bus_rd, sync, ctl_clear, bus_addr} == {4'b0100, seq[idx]},
                    (idx < 3) ? "R4" : "R5", {12'd0, core_rst_n, bus_rd, sync, ctl_clear, bus_addr},
                    {16'h4, seq[idx]});
                if (idx < 3) chk(!ctl_clear, "R8", {31'd0, ctl_clear}, 32'd0);
            end else if (n < N0 + 12) begin
                chk(core_rst_n && bus_rd && sync && bus_addr == {hi, lo}, "R7",
                    {13'd0, core_rst_n, bus_rd, sync, bus_addr}, {16'h7, hi, lo});
                if (n == N0 + 10)
                    chk(pc_load && pc_value == {hi, lo}, "R6", {15'd0, pc_load, pc_value}, {16'h1, hi, lo});
                else
                    chk(!pc_load, "R6", {31'd0, pc_load}, 32'd0);
            end else begin
                chk(!bus_rd && !sync && core_rst_n && !ctl_clear, "R7",
                    {28'd0, core_rst_n, bus_rd, sync, ctl_clear}, 32'h8);
            end
            if (g_at > 0 && n == g_at)       rst_pin_n = 1'b0;
            if (g_at > 0 && n == g_at + 100) rst_pin_n = 1'b1;
        end
    endtask

    task automatic hold_low(input int cyc);
        rst_pin_n = 1'b0;
        repeat (cyc) @(negedge clk);
    endtask

    initial begin
        por_n = 1'b0; rst_pin_n = 1'b0; sp = 8'h00; vlo = 8'h00; vhi = 8'h00;
        repeat (4) @(negedge clk);
        held("R10");
        por_n = 1'b1;
        hold_low(400);
        held("R2");
        boot(8'h80, 8'h34, 8'h12, 0, "R3");
        hold_low(400);
        held("R2");
        boot(8'h01, 8'hCD, 8'hAB, 10000, "R1");     // short glitch mid-wait
        hold_low(100);                               // short glitch while running
        rst_pin_n = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            chk(core_rst_n == 1'b1, "R1", {31'd0, core_rst_n}, 32'd1);
        end
        hold_low(400);
        held("R2");
        rst_pin_n = 1'b1;
        repeat (5000) @(negedge clk);
        held("R9");
        hold_low(400);
        held("R9");
        boot(8'h00, 8'h00, 8'hFF, 0, "R9");          // full fresh wait after restart
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule